// File: doc/BRIEF.md
# Sample Clock Ratio Tracker

This block estimates, in real time, the frequency ratio between two unrelated audio frame clocks: one that paces incoming samples and one that paces outgoing samples. A single fast master clock samples both frame clocks through synchronisers and measures each one's period as a count of master cycles between rising edges. On each output frame edge a sequential divider forms the raw ratio of output period to input period. A first-order low-pass loop then smooths that raw value.

The estimate is an unsigned fixed-point number with 2 integer and 16 fractional bits. Because the ratio is formed from the latest period of each clock, timing noise on either clock enters the loop in the same way and is attenuated by the same filter. A mode input selects the filter time constant. The slow setting gives a low corner and strong jitter rejection. The fast setting gives a higher corner and quicker settling when rates are moving. A downstream interpolator uses the estimate to pick its filter phase. The valid flag tells it when the estimate can first be trusted.

Top module: `ratio_tracker`

## Requirements
- R1: While rst_ni is low, and after its release until the first estimate exists, ratio_o is 0 and valid_o is 0.
- R2: Each frame clock passes through an SYNC_N-flop synchroniser, and its period is the exact number of master cycles between two consecutive synchronised rising edges. The estimate therefore settles to values derived from these exact counts.
- R3: The raw ratio is floor(Pout * 2^16 / Pin), unsigned Q2.16 in 18 bits. Pout is the output period and Pin the input period, both in master cycles. Non-integer ratios are truncated.
- R4: When Pout >= 4 * Pin the raw ratio saturates to 2^18 - 1.
- R5: valid_o stays low until each frame clock has shown at least three synchronised rising edges (two full periods). Once high, it stays high until reset.
- R6: The first estimate after valid_o rises equals the raw ratio of that update, with no filtering.
- R7: Every later update computes est <= est + ((raw - est) >>> k). The difference is signed and the shift is arithmetic, so it rounds toward minus infinity. Each step moves the estimate toward raw without passing it.
- R8: fast_i = 1 selects k = K_FAST and fast_i = 0 selects k = K_SLOW. The mode takes effect at the next update.
- R9: A change in the input clock period moves the estimate in the same way as a change in the output clock period.
- R10: ratio_o changes only at updates. Updates occur between 4 and RAT_W + 12 master cycles after an output frame rising edge, provided the output period is at least RAT_W + 8 master cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lr_in_i | input | 1 | Input-side frame clock, asynchronous |
| lr_out_i | input | 1 | Output-side frame clock, asynchronous |
| fast_i | input | 1 | 1 selects the fast settling constant, 0 the slow one |
| ratio_o | output | 18 | Filtered ratio Pout/Pin, unsigned Q2.16 |
| valid_o | output | 1 | Estimate is valid |

## Verification
The bench builds the tracker with K_SLOW = 3, K_FAST = 1 and a 10-bit period counter. With these values a full settling trajectory after a ratio step takes a few dozen updates instead of thousands. Every intermediate filter value can then be predicted and compared in a short run. The frame periods of 30 to 125 master cycles still leave room for the divider between output edges. They also make the exact-count path, a truncated non-integer ratio, a saturating ratio, and mode switches in both directions reachable within the cycle budget.

// File: rtl/ratio_tracker_pkg.sv
package ratio_tracker_pkg;
  localparam int FRAC_W = 16;
  localparam int INT_W  = 2;
  localparam int RAT_W  = INT_W + FRAC_W;
endpackage

// File: rtl/rt_period_meter.sv
module rt_period_meter #(
  parameter int CNT_W  = 12,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lr_i,
  output logic             edge_o,
  output logic [CNT_W-1:0] period_o,
  output logic             ok_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic [CNT_W-1:0]  cnt_q, period_q;
  logic [1:0]        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], lr_i};
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  assign edge_o = sync_q[SYNC_N-1] & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      period_q <= '0;
      seen_q   <= '0;
    end else if (edge_o) begin
      cnt_q    <= '0;
      period_q <= (&cnt_q) ? cnt_q : cnt_q + 1'b1;
      if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
    end else if (!(&cnt_q)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign period_o = period_q;
  assign ok_o     = (seen_q == 2'd3);

  AST_OK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |=> ok_o); // R5
  AST_OK_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> $past(edge_o)); // R5
endmodule

// File: rtl/rt_divider.sv
module rt_divider #(
  parameter int CNT_W  = 12,
  parameter int INT_W  = 2,
  parameter int FRAC_W = 16,
  localparam int RAT_W = INT_W + FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] num_i,
  input  logic [CNT_W-1:0] den_i,
  output logic             done_o,
  output logic [RAT_W-1:0] quo_o
);
  localparam int CW = $clog2(RAT_W + 1);
  localparam int PW = RAT_W + CNT_W;

  logic             busy_q, done_q, sat_q;
  logic [CW-1:0]    cnt_q;
  logic [CNT_W-1:0] rem_q, den_q, num_q;
  logic [RAT_W-1:0] sh_q, quo_q;
  logic [CNT_W:0]   trial_w;
  logic             fits_w, ovf_w;

  // Quotient below 2^INT_W iff (num >> INT_W) < den; that seeds the remainder.
  assign ovf_w   = (num_i >> INT_W) >= den_i;
  assign trial_w = {rem_q, sh_q[RAT_W-1]};
  assign fits_w  = trial_w >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sat_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      num_q  <= '0;
      sh_q   <= '0;
      quo_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        num_q <= num_i;
        den_q <= den_i;
        if (ovf_w) begin
          quo_q  <= '1;
          sat_q  <= 1'b1;
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          sat_q  <= 1'b0;
          busy_q <= 1'b1;
          cnt_q  <= CW'(RAT_W);
          rem_q  <= num_i >> INT_W;
          sh_q   <= {num_i[INT_W-1:0], {FRAC_W{1'b0}}};
        end
      end else if (busy_q) begin
        rem_q <= fits_w ? CNT_W'(trial_w - {1'b0, den_q}) : trial_w[CNT_W-1:0];
        quo_q <= {quo_q[RAT_W-2:0], fits_w};
        sh_q  <= sh_q << 1;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;

  logic [PW-1:0] prod_w, dividend_w, den_w;
  assign prod_w     = PW'(quo_q) * PW'(den_q);
  assign dividend_w = PW'({num_q, {FRAC_W{1'b0}}});
  assign den_w      = PW'(den_q);

  AST_DIV_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !sat_q) |-> (prod_w <= dividend_w && (dividend_w - prod_w) < den_w)); // R3
  AST_DIV_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && sat_q) |-> ((num_q >> INT_W) >= den_q)); // R4
endmodule

// File: rtl/rt_lowpass.sv
module rt_lowpass #(
  parameter int RAT_W  = 18,
  parameter int K_SLOW = 11,
  parameter int K_FAST = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             fast_i,
  input  logic [RAT_W-1:0] raw_i,
  output logic [RAT_W-1:0] est_o,
  output logic             valid_o
);
  logic [RAT_W-1:0]        est_q;
  logic                    valid_q;
  logic signed [RAT_W:0]   diff_w, step_w, next_w;

  assign diff_w = $signed({1'b0, raw_i}) - $signed({1'b0, est_q});
  assign step_w = fast_i ? (diff_w >>> K_FAST) : (diff_w >>> K_SLOW);
  assign next_w = $signed({1'b0, est_q}) + step_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      est_q   <= '0;
      valid_q <= 1'b0;
    end else if (upd_i) begin
      valid_q <= 1'b1;
      est_q   <= valid_q ? next_w[RAT_W-1:0] : raw_i;
    end
  end

  assign est_o   = est_q;
  assign valid_o = valid_q;

  AST_NEXT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> !next_w[RAT_W]); // R7
  AST_EST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(est_q)); // R10
  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && valid_q && raw_i >= est_q) |=> (est_q >= $past(est_q) && est_q <= $past(raw_i))); // R7
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && valid_q && raw_i < est_q) |=> (est_q < $past(est_q) && est_q >= $past(raw_i))); // R7
  AST_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !valid_q) |=> (est_q == $past(raw_i))); // R6
endmodule

// File: rtl/ratio_tracker.sv
module ratio_tracker
  import ratio_tracker_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int SYNC_N = 2,
  parameter int K_SLOW = 11,
  parameter int K_FAST = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lr_in_i,
  input  logic             lr_out_i,
  input  logic             fast_i,
  output logic [RAT_W-1:0] ratio_o,
  output logic             valid_o
);
  logic             in_edge, out_edge, in_ok, out_ok;
  logic [CNT_W-1:0] in_period, out_period;
  logic             start_q, div_done;
  logic [RAT_W-1:0] div_quo;

  rt_period_meter #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_in_meter (
    .clk_i, .rst_ni, .lr_i(lr_in_i),
    .edge_o(in_edge), .period_o(in_period), .ok_o(in_ok));

  rt_period_meter #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_out_meter (
    .clk_i, .rst_ni, .lr_i(lr_out_i),
    .edge_o(out_edge), .period_o(out_period), .ok_o(out_ok));

  // Start one cycle after the output edge so the fresh period is registered.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= out_edge & in_ok & out_ok;
  end

  rt_divider #(.CNT_W(CNT_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk_i, .rst_ni, .start_i(start_q),
    .num_i(out_period), .den_i(in_period),
    .done_o(div_done), .quo_o(div_quo));

  rt_lowpass #(.RAT_W(RAT_W), .K_SLOW(K_SLOW), .K_FAST(K_FAST)) u_lpf (
    .clk_i, .rst_ni, .upd_i(div_done), .fast_i,
    .raw_i(div_quo), .est_o(ratio_o), .valid_o);

  AST_IN_PERIOD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_edge |=> $stable(in_period)); // R2
  AST_OUT_PERIOD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_edge |=> $stable(out_period)); // R2
  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o); // R5
  AST_VALID_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (in_ok && out_ok)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (ratio_o == '0)); // R1
endmodule

// File: tb/ratio_tracker_bench.sv
module ratio_tracker_bench;
  import ratio_tracker_pkg::*;

  localparam int KS = 3;
  localparam int KF = 1;
  localparam int CW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lr_in = 1'b0, lr_out = 1'b0, fast = 1'b0;
  logic [RAT_W-1:0] ratio;
  logic valid;

  always #10 clk = ~clk;

  ratio_tracker #(.CNT_W(CW), .SYNC_N(2), .K_SLOW(KS), .K_FAST(KF)) u_ratio_tracker (
    .clk_i(clk), .rst_ni(rst_n), .lr_in_i(lr_in), .lr_out_i(lr_out),
    .fast_i(fast), .ratio_o(ratio), .valid_o(valid));

  typedef struct { int val; string tag; } item_t;
  item_t sb_q[$];
  item_t it;

  int n_cmp = 0, n_bad = 0, model_e = 0;
  int in_hi = 20, in_lo = 20, out_hi = 20, out_lo = 20;
  int in_rises = 0, out_rises = 0, cyc = 0, last_out = 0;
  bit run = 1'b0, pv = 1'b0, done_run = 1'b0;
  int pr = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int raw_of(int po, int pi);
    if (po >= 4 * pi) return (1 << RAT_W) - 1;
    return int'((longint'(po) << FRAC_W) / longint'(pi));
  endfunction

  task automatic push_traj(int raw, int k, string tag);
    int s;
    s = (raw - model_e) >>> k;
    while (s != 0) begin
      model_e += s;
      sb_q.push_back('{model_e, tag});
      s = (raw - model_e) >>> k;
    end
  endtask

  task automatic wait_out(int n);
    repeat (n) @(posedge lr_out);
    @(negedge clk);
  endtask

  task automatic phase_end(string tag);
    check(sb_q.size() == 0, tag, "pending updates", sb_q.size(), 0);
    check(int'(ratio) == model_e, tag, "settled estimate", int'(ratio), model_e);
  endtask

  // input frame clock driver: halves latched at each period start
  initial begin
    wait (run);
    @(negedge clk);
    forever begin
      int h, l;
      h = in_hi; l = in_lo;
      lr_in = 1'b1; in_rises++;
      repeat (h) @(negedge clk);
      lr_in = 1'b0;
      repeat (l) @(negedge clk);
    end
  end

  // output frame clock driver
  initial begin
    wait (run);
    @(negedge clk);
    forever begin
      int h, l;
      h = out_hi; l = out_lo;
      lr_out = 1'b1; out_rises++; last_out = cyc;
      repeat (h) @(negedge clk);
      lr_out = 1'b0;
      repeat (l) @(negedge clk);
    end
  end

  // monitor: pop one expected value per observed estimate change
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      if (valid && !pv)
        check(in_rises >= 3 && out_rises >= 3, "R5", "valid before two periods", in_rises, 3);
      if (!valid && pv)
        check(1'b0, "R5", "valid dropped", 0, 1);
      if (valid && (!pv || int'(ratio) != pr)) begin
        check((cyc - last_out) >= 4 && (cyc - last_out) <= 30, "R10",
              "update latency", cyc - last_out, 23);
        if (sb_q.size() == 0) begin
          check(1'b0, "R7", "unexpected update", int'(ratio), model_e);
        end else begin
          it = sb_q.pop_front();
          check(int'(ratio) == it.val, it.tag, "estimate", int'(ratio), it.val);
        end
      end
      pv = valid;
      pr = int'(ratio);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(ratio == '0, "R1", "ratio in reset", int'(ratio), 0);
    check(valid == 1'b0, "R1", "valid in reset", int'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ratio == '0 && valid == 1'b0, "R1", "after release", int'(ratio), 0);

    // seed at ratio 1.0
    model_e = raw_of(40, 40);
    sb_q.push_back('{model_e, "R6"});
    run = 1'b1;
    wait_out(10);
    phase_end("R6");

    // output period step, slow constant
    out_hi = 30; out_lo = 30;
    push_traj(raw_of(60, 40), KS, "R7");
    wait_out(120);
    phase_end("R7");

    // switch to fast with unchanged raw
    fast = 1'b1;
    push_traj(raw_of(60, 40), KF, "R8");
    wait_out(20);
    phase_end("R8");

    // input period step: ratio 2.0
    in_hi = 15; in_lo = 15;
    push_traj(raw_of(60, 30), KF, "R9");
    wait_out(40);
    phase_end("R9");

    // non-integer ratio 35/30, truncated
    out_hi = 17; out_lo = 18;
    push_traj(raw_of(35, 30), KF, "R3");
    wait_out(40);
    phase_end("R3");

    // ratio beyond range saturates
    out_hi = 62; out_lo = 63;
    push_traj(raw_of(125, 30), KF, "R4");
    wait_out(40);
    phase_end("R4");
    check(model_e >= (1 << RAT_W) - 2, "R4", "model near saturation", model_e, (1 << RAT_W) - 1);

    // back to slow, exact counts 40/30
    fast = 1'b0;
    push_traj(raw_of(125, 30), KS, "R8");
    out_hi = 20; out_lo = 20;
    push_traj(raw_of(40, 30), KS, "R2");
    wait_out(130);
    phase_end("R2");

    done_run = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule